// File: doc/BRIEF.md
# Quarter-Cycle I/O Bus Sequencer

This block produces the bus control timing for a small 8-bit controller-style I/O interface. Every instruction cycle lasts four clocks. Each clock is one quarter. Quarters one and two form the input phase, and quarters three and four form the output phase. The block takes decoded requests from an external instruction decoder: a select request, a write request, a bank choice and an instruction-valid flag. It turns these into a select strobe, a write strobe, complementary left and right bank enables, an input latch window and an output driver enable. Control outputs change state only where the input phase or the output phase begins.

A halt request is sampled once per cycle, at the close of quarter one. A sampled halt raises a flag. From the next phase boundary onward the block drives no strobes, opens no latch window and turns no driver on. A later quarter-one sample that finds halt low releases it. The decoder, the ALU and the register file are outside this block.

Top module: `qc_bus_seq`

## Requirements
- R1: `latch_en_o` is high in quarters one and two and low in quarters three and four of every cycle that is not halted. It is low after reset until the first quarter-one start.
- R2: `drv_en_o` goes high at the start of quarter three and stays high through quarter four. It is low in quarters one and two.
- R3: `sc_o` and `wc_o` change only at the start of quarter one or quarter three. Each takes its request input as it stands at the clock edge that opens that quarter. Request values at any other edge are ignored.
- R4: `sc_o` and `wc_o` are never high together. When select and write are both requested, only `sc_o` is raised.
- R5: `lbank_o` and `rbank_o` are complementary at all times. `bank_req_i` = 0 selects the left bank and 1 selects the right bank.
- R6: For the input phase, the bank is taken from `bank_req_i` at the start of quarter one if `instr_vld_i` is high there. Otherwise it is taken at the start of quarter two if `instr_vld_i` is high then. If the instruction is valid at neither edge, the bank is held.
- R7: For the output phase, the bank is taken from `bank_req_i` at the start of quarter three.
- R8: `halt_i` is sampled only at the close of quarter one. `halted_o` takes that value at the start of quarter two. Halt values in other quarters are ignored.
- R9: While halted, every later phase boundary drives `sc_o`, `wc_o`, `latch_en_o` and `drv_en_o` low, and the bank selection is held.
- R10: A quarter-one sample of halt low clears `halted_o` at the start of quarter two. Normal outputs resume at the next quarter-three start.
- R11: Synchronous reset places the sequencer in quarter one with all strobes, the latch window and the driver off, the left bank selected and `halted_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per quarter-cycle |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Halt request, sampled at the close of quarter one |
| instr_vld_i | input | 1 | Current instruction is valid |
| sel_req_i | input | 1 | Decoded select-command request |
| wr_req_i | input | 1 | Decoded write-command request |
| bank_req_i | input | 1 | Requested bank (0 left, 1 right) |
| sc_o | output | 1 | Select-command strobe |
| wc_o | output | 1 | Write-command strobe |
| lbank_o | output | 1 | Left bank enable |
| rbank_o | output | 1 | Right bank enable |
| latch_en_o | output | 1 | I/O bus and ALU input latch window |
| drv_en_o | output | 1 | I/O bus tristate driver enable |
| halted_o | output | 1 | Sequencer is halted |

## Verification
The driver runs whole instruction cycles and sets the requests separately for each quarter. It holds active values on the select, write and bank inputs at the edges the block must ignore. Any response at the wrong quarter then appears as a miscompare.

Several patterns are tried:
- Select alone, write alone, and both together. These separate plain sampling from the select-over-write priority.
- A valid instruction at quarter one, a valid instruction that arrives only at quarter two, and no valid instruction at all. These separate the immediate bank update, the late update and the hold.
- Halt pulses in quarters two to four, against a halt present at the close of quarter one. This separates the single sampling point from a level-sensitive halt.
- A run of halted cycles with requests active, followed by a release. This shows that nothing leaks out while halted and that output resumes at the first quarter-three start.

// File: rtl/qc_bus_pkg.sv
package qc_bus_pkg;
  localparam int QC_QTRS = 4;
  localparam int QC_PH_W = $clog2(QC_QTRS);

  typedef enum logic [QC_PH_W-1:0] {
    QC_Q1 = 2'd0,
    QC_Q2 = 2'd1,
    QC_Q3 = 2'd2,
    QC_Q4 = 2'd3
  } qc_qtr_e;
endpackage

// File: rtl/qc_phase_ctr.sv
module qc_phase_ctr
  import qc_bus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output qc_qtr_e ph_o
);
  logic [QC_PH_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign ph_o = qc_qtr_e'(cnt);
endmodule

// File: rtl/qc_halt_ctl.sv
module qc_halt_ctl (
  input  logic clk,
  input  logic rst,
  input  logic smp_i,
  input  logic halt_i,
  output logic halted_o
);
  always_ff @(posedge clk) begin
    if (rst)        halted_o <= 1'b0;
    else if (smp_i) halted_o <= halt_i;
  end
endmodule

// File: rtl/qc_bank_sel.sv
module qc_bank_sel (
  input  logic clk,
  input  logic rst,
  input  logic open_in_i,
  input  logic late_in_i,
  input  logic open_out_i,
  input  logic halted_i,
  input  logic vld_i,
  input  logic req_i,
  output logic right_o
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      right_o <= 1'b0;
      pend    <= 1'b0;
    end else if (open_in_i) begin
      if (halted_i) begin
        pend <= 1'b0;
      end else if (vld_i) begin
        right_o <= req_i;
        pend    <= 1'b0;
      end else begin
        pend <= 1'b1;
      end
    end else if (late_in_i) begin
      if (pend && vld_i && !halted_i) right_o <= req_i;
      pend <= 1'b0;
    end else if (open_out_i && !halted_i) begin
      right_o <= req_i;
    end
  end
endmodule

// File: rtl/qc_strobe_gen.sv
module qc_strobe_gen (
  input  logic clk,
  input  logic rst,
  input  logic open_in_i,
  input  logic open_out_i,
  input  logic halted_i,
  input  logic sel_i,
  input  logic wr_i,
  output logic sc_o,
  output logic wc_o,
  output logic lat_o,
  output logic drv_o
);
  logic run;
  assign run = !halted_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_o  <= 1'b0;
      wc_o  <= 1'b0;
      lat_o <= 1'b0;
      drv_o <= 1'b0;
    end else if (open_in_i || open_out_i) begin
      sc_o  <= run && sel_i;
      wc_o  <= run && wr_i && !sel_i;
      lat_o <= run && open_in_i;
      drv_o <= run && open_out_i;
    end
  end
endmodule

// File: rtl/qc_bus_seq.sv
module qc_bus_seq
  import qc_bus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halt_i,
  input  logic instr_vld_i,
  input  logic sel_req_i,
  input  logic wr_req_i,
  input  logic bank_req_i,
  output logic sc_o,
  output logic wc_o,
  output logic lbank_o,
  output logic rbank_o,
  output logic latch_en_o,
  output logic drv_en_o,
  output logic halted_o
);
  qc_qtr_e ph;
  logic    open_in, late_in, open_out, bank_right;

  // edge that starts Q1, edge that starts Q2, edge that starts Q3
  assign open_in  = (ph == QC_Q4);
  assign late_in  = (ph == QC_Q1);
  assign open_out = (ph == QC_Q2);

  qc_phase_ctr u_ph (
    .clk (clk),
    .rst (rst),
    .ph_o(ph)
  );

  qc_halt_ctl u_halt (
    .clk     (clk),
    .rst     (rst),
    .smp_i   (late_in),
    .halt_i  (halt_i),
    .halted_o(halted_o)
  );

  qc_bank_sel u_bank (
    .clk       (clk),
    .rst       (rst),
    .open_in_i (open_in),
    .late_in_i (late_in),
    .open_out_i(open_out),
    .halted_i  (halted_o),
    .vld_i     (instr_vld_i),
    .req_i     (bank_req_i),
    .right_o   (bank_right)
  );

  qc_strobe_gen u_stb (
    .clk       (clk),
    .rst       (rst),
    .open_in_i (open_in),
    .open_out_i(open_out),
    .halted_i  (halted_o),
    .sel_i     (sel_req_i),
    .wr_i      (wr_req_i),
    .sc_o      (sc_o),
    .wc_o      (wc_o),
    .lat_o     (latch_en_o),
    .drv_o     (drv_en_o)
  );

  assign rbank_o = bank_right;
  assign lbank_o = !bank_right;
endmodule

// File: rtl/qc_bus_seq_chk.sv
module qc_bus_seq_chk (
  input logic clk,
  input logic rst,
  input logic halt_i,
  input logic instr_vld_i,
  input logic sel_req_i,
  input logic wr_req_i,
  input logic bank_req_i,
  input logic sc_o,
  input logic wc_o,
  input logic lbank_o,
  input logic rbank_o,
  input logic latch_en_o,
  input logic drv_en_o,
  input logic halted_o
);
  logic [1:0] qc;

  always_ff @(posedge clk) begin
    if (rst) qc <= 2'd0;
    else     qc <= qc + 2'd1;
  end

  p_excl_r4: assert property (@(posedge clk) disable iff (rst) !(sc_o && wc_o));
  p_bank_cmpl_r5: assert property (@(posedge clk) disable iff (rst) lbank_o != rbank_o);
  p_latch_win_r1: assert property (@(posedge clk) disable iff (rst) latch_en_o |-> (qc == 2'd0 || qc == 2'd1));
  p_drv_win_r2: assert property (@(posedge clk) disable iff (rst) drv_en_o |-> (qc == 2'd2 || qc == 2'd3));
  p_sc_stable_r3: assert property (@(posedge clk) disable iff (rst) (qc == 2'd1 || qc == 2'd3) |-> $stable(sc_o));
  p_wc_stable_r3: assert property (@(posedge clk) disable iff (rst) (qc == 2'd1 || qc == 2'd3) |-> $stable(wc_o));
  p_halt_smp_r8: assert property (@(posedge clk) disable iff (rst) (qc != 2'd1) |-> $stable(halted_o));
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst) (halted_o && qc == 2'd0) |-> !(sc_o || wc_o || latch_en_o || drv_en_o));
endmodule

bind qc_bus_seq qc_bus_seq_chk u_chk (.*);

// File: tb/qc_bus_seq_tb.sv
module qc_bus_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_i = 1'b0, instr_vld_i = 1'b0, sel_req_i = 1'b0, wr_req_i = 1'b0, bank_req_i = 1'b0;
  logic sc_o, wc_o, lbank_o, rbank_o, latch_en_o, drv_en_o, halted_o;

  int n_vec = 0;
  int n_bad = 0;
  logic done = 1'b0;

  // expected order: halted, sc, wc, lbank, rbank, latch, drv
  logic [6:0] exp_q[$];

  // bench reference state
  logic m_halt = 1'b0, m_pend = 1'b0, m_right = 1'b0;
  logic m_sc = 1'b0, m_wc = 1'b0, m_lat = 1'b0, m_drv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qc_bus_seq u_dut (.*);

  task automatic cmp(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t act=%b exp=%b", tag, $time, act, exp);
    end
  endtask

  // monitor: pops expected items and compares them away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [6:0] e;
      e = exp_q.pop_front();
      cmp(halted_o,   e[6], "R8/R10 halted_o");
      cmp(sc_o,       e[5], "R3/R4 sc_o");
      cmp(wc_o,       e[4], "R3/R4 wc_o");
      cmp(lbank_o,    e[3], "R5/R6/R7 lbank_o");
      cmp(rbank_o,    e[2], "R5/R6/R7 rbank_o");
      cmp(latch_en_o, e[1], "R1/R9 latch_en_o");
      cmp(drv_en_o,   e[0], "R2/R9 drv_en_o");
    end
  end

  // one instruction cycle, starting at a negedge inside Q1
  // h: halt at the end of Q1, hx: halt in other quarters, vl/bl: late valid/bank,
  // s_o/w_o/b_o: output phase requests, s_i/w_i/b_i/v_i: next input phase requests
  task automatic run_cycle(input logic h, input logic hx, input logic vl, input logic bl,
                           input logic s_o, input logic w_o, input logic b_o,
                           input logic s_i, input logic w_i, input logic b_i, input logic v_i);
    for (int k = 0; k < 4; k++) begin
      halt_i      = (k == 0) ? h : hx;
      instr_vld_i = (k == 0) ? vl : (k == 3) ? v_i : 1'b1;
      bank_req_i  = (k == 0) ? bl : (k == 1) ? b_o : (k == 3) ? b_i : ~m_right;
      sel_req_i   = (k == 1) ? s_o : (k == 3) ? s_i : 1'b1;
      wr_req_i    = (k == 1) ? w_o : (k == 3) ? w_i : 1'b1;
      @(posedge clk);
      #1;
      case (k)
        0: begin
          if (!m_halt && m_pend && vl) m_right = bl;
          m_pend = 1'b0;
          m_halt = h;
        end
        1: begin
          m_lat = 1'b0;
          m_drv = !m_halt;
          m_sc  = !m_halt && s_o;
          m_wc  = !m_halt && w_o && !s_o;
          if (!m_halt) m_right = b_o;
        end
        3: begin
          m_drv = 1'b0;
          m_lat = !m_halt;
          m_sc  = !m_halt && s_i;
          m_wc  = !m_halt && w_i && !s_i;
          if (m_halt) m_pend = 1'b0;
          else if (v_i) begin m_right = b_i; m_pend = 1'b0; end
          else m_pend = 1'b1;
        end
        default: ;
      endcase
      exp_q.push_back({m_halt, m_sc, m_wc, !m_right, m_right, m_lat, m_drv});
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    cmp(sc_o, 1'b0, "R11 sc_o");
    cmp(wc_o, 1'b0, "R11 wc_o");
    cmp(lbank_o, 1'b1, "R11 lbank_o");
    cmp(rbank_o, 1'b0, "R11 rbank_o");
    cmp(latch_en_o, 1'b0, "R11 latch_en_o");
    cmp(drv_en_o, 1'b0, "R11 drv_en_o");
    cmp(halted_o, 1'b0, "R11 halted_o");

    // R3 plain write out, select in; R7 right bank out
    run_cycle(0,0,0,0, 0,1,1, 1,0,1,1);
    // R4 both requested in each phase
    run_cycle(0,0,0,0, 1,1,0, 1,1,0,1);
    // R6 no valid at Q1 start, bank held, pend set
    run_cycle(0,0,0,0, 0,0,1, 0,1,0,0);
    // R6 late valid at Q2 start takes bank left, then pend again
    run_cycle(0,0,1,0, 0,0,1, 0,0,1,0);
    // R6 late valid absent: bank held
    run_cycle(0,0,0,0, 1,0,0, 0,1,1,1);
    // R8 halt present outside quarter one is ignored
    run_cycle(0,1,0,0, 0,1,1, 1,0,0,1);
    // R9 halt sampled, then stays halted with requests active
    run_cycle(1,1,1,1, 1,0,1, 1,0,1,1);
    run_cycle(1,0,1,0, 0,1,0, 0,1,0,1);
    // R10 release, outputs resume at Q3
    run_cycle(0,0,1,1, 0,1,0, 1,0,1,1);
    run_cycle(0,0,0,0, 1,0,1, 0,1,0,1);
    run_cycle(0,0,0,0, 0,0,0, 0,0,0,1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule